// File: doc/BRIEF.md
# Windowed PHY Register Access Bridge

The bridge lets a host issue single-word reads and writes to a PHY's internal 16-bit control-register space when that space can only be reached through a narrow memory-mapped window. Each internal register touch is a raw pair of bus accesses. The first is a window-select write that places the device number and the upper register-address bits. The second is the data access at an offset derived from the lower address bits.

Every host request goes through a small handshake with three internal registers: a control register, an address register and a data register. The bridge first polls the control register until its busy bit is clear. It then loads the address register, and for a write also the data register. Next it writes a start command to the control register. For a read it polls again and then fetches the data register.

A programmable poll limit bounds each busy-wait, so a stuck PHY produces an error response instead of a hang. The host sees one transaction at a time: ready drops on acceptance and returns with a one-cycle response pulse.

Top module: `phy_win_bridge`

## Requirements
- R1: After reset `req_ready` is 1, and `bus_req` and `rsp_valid` are 0.
- R2: Every internal register access is a window write to bus byte offset 0x800, immediately followed by one access at offset `(reg & 0x1ff) << 2`, with no other bus access in between. The internal registers are: control 0x80a0, address 0x80a1, data 0x80a2.
- R3: Every request starts by reading the control register and repeats that read until bit 0 (busy) reads 0.
- R4: A read proceeds in this order: write the target address to the address register, write 0x0001 to control, poll control until not busy, then read the data register. The value read is returned on `rsp_rdata` with `rsp_err` = 0.
- R5: A write proceeds in this order: write the address register, write the data register, then write 0x0003 to control. The response follows that last control write with no further polling.
- R6: When a poll reads busy for the `poll_limit`-th time in a row, the request ends with `rsp_err` = 1 and `rsp_rdata` = 0, and no further bus access is made. A limit of 0 behaves as a limit of 1.
- R7: The busy count restarts for each poll phase, so the limit applies separately to the poll before start and the poll after start.
- R8: `req_ready` is low from the cycle after acceptance until `rsp_valid` rises. `rsp_valid` lasts exactly one cycle and coincides with `req_ready` returning high.
- R9: While `bus_req` is high and `bus_ack` is low, `bus_addr`, `bus_we` and `bus_wdata` hold steady.
- R10: The window value is `(dev << 7) | (reg >> 9)`, which places the 5-bit device number in bits 11:7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY internal register address |
| req_wdata | input | 16 | Write data |
| req_dev | input | 5 | PHY device number |
| req_ready | output | 1 | Bridge idle and able to accept a request |
| poll_limit | input | 16 | Maximum consecutive busy reads per poll phase |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_err | output | 1 | Completion ended by the poll limit |
| rsp_rdata | output | 16 | Read result |
| bus_req | output | 1 | Bus access presented |
| bus_we | output | 1 | Bus access is a write |
| bus_addr | output | 12 | Bus byte offset |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid with `bus_ack` |
| bus_ack | input | 1 | Bus access complete |

## Verification
The hardest case to reach from the ports is a poll limit expiring in the second poll phase, after the start command has already been issued. Only there does the error path leave a started PHY operation behind. The bench's register model lets each test preload a busy count for the phase before start, and a separate busy count that is armed by the start write itself. A read whose second phase stays busy past a small limit therefore hits this path exactly. The model also decodes every window and raw pair with random acknowledge delays, so a split pair or a wrong window value is caught on the access where it happens.

// File: rtl/phy_win_pkg.sv
package phy_win_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL_PRE,
        ST_SET_ADDR,
        ST_SET_DATA,
        ST_KICK,
        ST_POLL_POST,
        ST_GET_DATA
    } step_e;

    // internal register addresses of the PHY handshake
    localparam logic [15:0] IREG_CTL  = 16'h80a0;
    localparam logic [15:0] IREG_ADDR = 16'h80a1;
    localparam logic [15:0] IREG_DATA = 16'h80a2;

    // control register commands: bit 0 start, bit 1 write
    localparam logic [15:0] CMD_GO    = 16'h0001;
    localparam logic [15:0] CMD_GO_WR = 16'h0003;

endpackage

// File: rtl/phy_win_map.sv
// Splits an internal register address into a window value and a raw offset.
module phy_win_map #(
    parameter int DEV_W     = 5,
    parameter int REG_W     = 16,
    parameter int PAGE_BITS = 9,
    parameter int OFF_W     = 12,
    parameter int WIN_W     = DEV_W + REG_W - PAGE_BITS
) (
    input  logic [DEV_W-1:0] dev_i,
    input  logic [REG_W-1:0] reg_i,
    output logic [WIN_W-1:0] win_o,
    output logic [OFF_W-1:0] off_o
);
    localparam int RAW_W = PAGE_BITS + 2;

    assign win_o = {dev_i, reg_i[REG_W-1:PAGE_BITS]};
    assign off_o = {{(OFF_W-RAW_W){1'b0}}, reg_i[PAGE_BITS-1:0], 2'b00};

endmodule

// File: rtl/phy_win_poll.sv
// Counts consecutive busy reads within one poll phase.
module phy_win_poll #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             busy_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             last_o
);
    localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (busy_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // the busy read now on the bus is the last one allowed
    assign last_o = ({1'b0, cnt_q} + ONE) >= {1'b0, limit_i};

endmodule

// File: rtl/phy_win_bridge.sv
module phy_win_bridge
    import phy_win_pkg::*;
#(
    parameter int DEV_W     = 5,
    parameter int REG_W     = 16,
    parameter int DATA_W    = 16,
    parameter int PAGE_BITS = 9,
    parameter int OFF_W     = 12,
    parameter int CNT_W     = 16,
    parameter int WIN_OFF   = 'h800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [REG_W-1:0]  req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DEV_W-1:0]  req_dev,
    output logic              req_ready,
    input  logic [CNT_W-1:0]  poll_limit,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [OFF_W-1:0]  bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack
);
    localparam int WIN_W = DEV_W + REG_W - PAGE_BITS;
    localparam logic [OFF_W-1:0] WIN_AT  = OFF_W'(WIN_OFF);
    localparam logic [REG_W-1:0] R_CTL   = REG_W'(IREG_CTL);
    localparam logic [REG_W-1:0] R_ADDR  = REG_W'(IREG_ADDR);
    localparam logic [REG_W-1:0] R_DATA  = REG_W'(IREG_DATA);

    typedef struct packed {
        step_e             step;
        logic              raw;    // 0: window write pending, 1: raw access pending
        logic              wr;
        logic [REG_W-1:0]  addr;
        logic [DATA_W-1:0] wdata;
        logic [DEV_W-1:0]  dev;
        logic              rsp;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t s_d, s_q;

    logic [REG_W-1:0]  tgt;
    logic              acc_we;
    logic [DATA_W-1:0] acc_val;
    logic [WIN_W-1:0]  win;
    logic [OFF_W-1:0]  off;
    logic              poll_step;
    logic              poll_busy;
    logic              poll_clear;
    logic              poll_last;
    logic              accept;

    // register targeted by the current step
    always_comb begin
        tgt     = R_CTL;
        acc_we  = 1'b0;
        acc_val = '0;
        unique case (s_q.step)
            ST_SET_ADDR: begin
                tgt     = R_ADDR;
                acc_we  = 1'b1;
                acc_val = DATA_W'(s_q.addr);
            end
            ST_SET_DATA: begin
                tgt     = R_DATA;
                acc_we  = 1'b1;
                acc_val = s_q.wdata;
            end
            ST_KICK: begin
                tgt     = R_CTL;
                acc_we  = 1'b1;
                acc_val = s_q.wr ? DATA_W'(CMD_GO_WR) : DATA_W'(CMD_GO);
            end
            ST_GET_DATA: begin
                tgt     = R_DATA;
            end
            default: begin
                tgt     = R_CTL;
            end
        endcase
    end

    phy_win_map #(
        .DEV_W    (DEV_W),
        .REG_W    (REG_W),
        .PAGE_BITS(PAGE_BITS),
        .OFF_W    (OFF_W),
        .WIN_W    (WIN_W)
    ) u_map (
        .dev_i(s_q.dev),
        .reg_i(tgt),
        .win_o(win),
        .off_o(off)
    );

    assign poll_step  = (s_q.step == ST_POLL_PRE) || (s_q.step == ST_POLL_POST);
    assign poll_busy  = s_q.raw && bus_ack && poll_step && bus_rdata[0];
    assign poll_clear = accept || (s_q.raw && bus_ack && poll_step && !bus_rdata[0]);

    phy_win_poll #(
        .CNT_W(CNT_W)
    ) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(poll_clear),
        .busy_i (poll_busy),
        .limit_i(poll_limit),
        .last_o (poll_last)
    );

    always_comb begin
        s_d     = s_q;
        s_d.rsp = 1'b0;
        s_d.err = 1'b0;
        accept  = 1'b0;
        if (s_q.step == ST_IDLE) begin
            if (req_valid) begin
                accept      = 1'b1;
                s_d.step    = ST_POLL_PRE;
                s_d.raw     = 1'b0;
                s_d.wr      = req_write;
                s_d.addr    = req_addr;
                s_d.wdata   = req_wdata;
                s_d.dev     = req_dev;
                s_d.rdata   = '0;
            end
        end else if (bus_ack) begin
            if (!s_q.raw) begin
                s_d.raw = 1'b1;
            end else begin
                s_d.raw = 1'b0;
                unique case (s_q.step)
                    ST_POLL_PRE, ST_POLL_POST: begin
                        if (bus_rdata[0]) begin
                            if (poll_last) begin
                                s_d.step = ST_IDLE;
                                s_d.rsp  = 1'b1;
                                s_d.err  = 1'b1;
                            end
                        end else begin
                            s_d.step = (s_q.step == ST_POLL_PRE) ? ST_SET_ADDR : ST_GET_DATA;
                        end
                    end
                    ST_SET_ADDR: s_d.step = s_q.wr ? ST_SET_DATA : ST_KICK;
                    ST_SET_DATA: s_d.step = ST_KICK;
                    ST_KICK: begin
                        if (s_q.wr) begin
                            s_d.step = ST_IDLE;
                            s_d.rsp  = 1'b1;
                        end else begin
                            s_d.step = ST_POLL_POST;
                        end
                    end
                    ST_GET_DATA: begin
                        s_d.step  = ST_IDLE;
                        s_d.rsp   = 1'b1;
                        s_d.rdata = bus_rdata;
                    end
                    default: s_d.step = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{step: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = (s_q.step == ST_IDLE);
    assign rsp_valid = s_q.rsp;
    assign rsp_err   = s_q.err;
    assign rsp_rdata = s_q.rdata;
    assign bus_req   = (s_q.step != ST_IDLE);
    assign bus_we    = !s_q.raw || acc_we;
    assign bus_addr  = s_q.raw ? off : WIN_AT;
    assign bus_wdata = s_q.raw ? acc_val : DATA_W'(win);

endmodule

// File: rtl/phy_win_bridge_chk.sv
module phy_win_bridge_chk #(
    parameter int DATA_W  = 16,
    parameter int OFF_W   = 12,
    parameter int WIN_OFF = 'h800
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_we,
    input logic [OFF_W-1:0]  bus_addr,
    input logic [DATA_W-1:0] bus_wdata
);
    localparam logic [OFF_W-1:0] WIN_AT = OFF_W'(WIN_OFF);

    // R9: presented access holds until acknowledged
    assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable({bus_addr, bus_we, bus_wdata})));

    // R2: a completed window write is followed directly by a raw access
    assert_pair_atomic_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_we && bus_addr == WIN_AT) |=> (bus_req && bus_addr != WIN_AT));

    // R8: ready drops once a request is taken
    assert_ready_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8: response strobe is a single cycle while idle
    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_rsp_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    // R1: no bus traffic while idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_req);

    // R6: error flag only with a response
    assert_err_with_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

endmodule

bind phy_win_bridge phy_win_bridge_chk #(
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W),
    .WIN_OFF(WIN_OFF)
) u_chk (.*);

// File: tb/phy_win_bridge_bench.sv
module phy_win_bridge_bench;

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic        req_write;
    logic [15:0] req_addr;
    logic [15:0] req_wdata;
    logic [4:0]  req_dev;
    logic        req_ready;
    logic [15:0] poll_limit;
    logic        rsp_valid;
    logic        rsp_err;
    logic [15:0] rsp_rdata;
    logic        bus_req;
    logic        bus_we;
    logic [11:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        bus_ack;

    int checks = 0;
    int errors = 0;

    phy_win_bridge u_phy_win_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_dev   (req_dev),
        .req_ready (req_ready),
        .poll_limit(poll_limit),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- PHY register model ----------------
    // log kinds: 0 ctl read, 1 addr write, 2 data write, 3 ctl write, 4 data read, 5 other
    int          busy_left = 0;
    int          post_busy = 0;
    logic [15:0] addr_reg = '0;
    logic [15:0] data_reg = '0;
    logic [11:0] win_reg = '0;
    bit          win_open = 0;
    logic [4:0]  cur_dev = '0;
    int          log_n = 0;
    int          log_kind [0:63];
    logic [15:0] log_val [0:63];
    int          ack_wait = 0;

    task automatic serve();
        logic [15:0] ireg;
        int kind;
        if (bus_addr == 12'h800) begin
            chk(bus_we && !win_open, "R2", "window write placement", int'(win_open), 0);
            chk(bus_wdata[11:7] == cur_dev, "R10", "window device field",
                int'(bus_wdata[11:7]), int'(cur_dev));
            win_reg  = bus_wdata[11:0];
            win_open = 1;
        end else begin
            if (!win_open) begin
                chk(1'b0, "R2", "raw access without window", int'(bus_addr), 'h800);
            end
            win_open = 0;
            ireg = {win_reg[6:0], bus_addr[10:2]};
            kind = 5;
            if (ireg == 16'h80a0) begin
                kind = bus_we ? 3 : 0;
            end else if (ireg == 16'h80a1) begin
                kind = bus_we ? 1 : 5;
            end else if (ireg == 16'h80a2) begin
                kind = bus_we ? 2 : 4;
            end
            case (kind)
                0: begin
                    bus_rdata = {15'b0, busy_left > 0};
                    if (busy_left > 0) busy_left--;
                end
                1: addr_reg = bus_wdata;
                2: data_reg = bus_wdata;
                3: begin
                    if (bus_wdata[0]) begin
                        busy_left = post_busy;
                        if (!bus_wdata[1]) data_reg = addr_reg ^ 16'hC3A5;
                    end
                end
                4: bus_rdata = data_reg;
                default: bus_rdata = 16'hDEAD;
            endcase
            if (log_n < 64) begin
                log_kind[log_n] = kind;
                log_val[log_n]  = bus_we ? bus_wdata : bus_rdata;
            end
            log_n++;
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack   = 1'b0;
            bus_rdata = '0;
            ack_wait  = 0;
        end else if (bus_ack) begin
            bus_ack  = 1'b0;
            ack_wait = int'($urandom_range(0, 2));
        end else if (bus_req) begin
            if (ack_wait > 0) begin
                ack_wait--;
            end else begin
                serve();
                bus_ack = 1'b1;
            end
        end
    end

    // ---------------- expected access list ----------------
    int          exp_n = 0;
    int          exp_kind [0:63];
    logic [15:0] exp_val [0:63];

    task automatic exp_clear();
        exp_n = 0;
    endtask

    task automatic exp_push(input int k, input logic [15:0] v);
        exp_kind[exp_n] = k;
        exp_val[exp_n]  = v;
        exp_n++;
    endtask

    task automatic exp_polls(input int n);
        for (int i = 0; i < n; i++) exp_push(0, 16'h0);
    endtask

    task automatic check_log(input string req);
        int bad = 0;
        chk(log_n == exp_n, req, "access count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            if (log_kind[i] != exp_kind[i]) bad++;
            else if (exp_kind[i] >= 1 && exp_kind[i] <= 3 && log_val[i] != exp_val[i]) bad++;
        end
        chk(bad == 0, req, "access order/value mismatches", bad, 0);
    endtask

    // ---------------- host side ----------------
    task automatic run_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          input logic [4:0] dev, input int pre,
                          output bit err, output logic [15:0] rd);
        bit ready_bad = 0;
        int n = 0;
        @(negedge clk);
        cur_dev   = dev;
        log_n     = 0;
        busy_left = pre;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_dev   = dev;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && n < 5000) begin
            if (req_ready) ready_bad = 1;
            @(negedge clk);
            n++;
        end
        chk(!ready_bad, "R8", "ready high during request", int'(ready_bad), 0);
        chk(rsp_valid == 1'b1, "R8", "response strobe seen", int'(rsp_valid), 1);
        err = rsp_err;
        rd  = rsp_rdata;
        chk(req_ready == 1'b1, "R8", "ready with response", int'(req_ready), 1);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8", "response lasts one cycle", int'(rsp_valid), 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(bus_req == 1'b0, "R1", "bus idle after reset", int'(bus_req), 0);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", int'(rsp_valid), 0);
    endtask

    task automatic t_read(input logic [15:0] a, input logic [4:0] dev,
                          input int pre, input int post, input int lim, input string req);
        bit err;
        logic [15:0] rd;
        poll_limit = 16'(lim);
        post_busy  = post;
        run_op(1'b0, a, 16'h0, dev, pre, err, rd);
        exp_clear();
        exp_polls(pre + 1);
        exp_push(1, a);
        exp_push(3, 16'h0001);
        exp_polls(post + 1);
        exp_push(4, 16'h0);
        check_log(req);
        chk(err == 1'b0, "R4", "read error flag", int'(err), 0);
        chk(rd == (a ^ 16'hC3A5), "R4", "read data", int'(rd), int'(a ^ 16'hC3A5));
    endtask

    task automatic t_write(input logic [15:0] a, input logic [15:0] d,
                           input logic [4:0] dev, input int pre);
        bit err;
        logic [15:0] rd;
        poll_limit = 16'd1000;
        post_busy  = 5;
        run_op(1'b1, a, d, dev, pre, err, rd);
        exp_clear();
        exp_polls(pre + 1);
        exp_push(1, a);
        exp_push(2, d);
        exp_push(3, 16'h0003);
        check_log("R5");
        chk(err == 1'b0, "R5", "write error flag", int'(err), 0);
        chk(data_reg == d, "R5", "PHY data register", int'(data_reg), int'(d));
        busy_left = 0;
    endtask

    task automatic t_timeout_pre(input int lim, input int expect_polls);
        bit err;
        logic [15:0] rd;
        poll_limit = 16'(lim);
        post_busy  = 0;
        run_op(1'b1, 16'h4321, 16'h1111, 5'h03, 100, err, rd);
        repeat (10) @(negedge clk);
        exp_clear();
        exp_polls(expect_polls);
        check_log("R6");
        chk(err == 1'b1, "R6", "timeout error flag", int'(err), 1);
        chk(bus_req == 1'b0, "R6", "bus idle after timeout", int'(bus_req), 0);
        busy_left = 0;
    endtask

    task automatic t_timeout_post();
        bit err;
        logic [15:0] rd;
        poll_limit = 16'd2;
        post_busy  = 50;
        run_op(1'b0, 16'h0abc, 16'h0, 5'h07, 0, err, rd);
        exp_clear();
        exp_polls(1);
        exp_push(1, 16'h0abc);
        exp_push(3, 16'h0001);
        exp_polls(2);
        check_log("R6");
        chk(err == 1'b1, "R6", "second-phase timeout flag", int'(err), 1);
        chk(rd == 16'h0, "R6", "read data on timeout", int'(rd), 0);
        busy_left = 0;
    endtask

    initial begin
        rst_n      = 1'b0;
        req_valid  = 1'b0;
        req_write  = 1'b0;
        req_addr   = '0;
        req_wdata  = '0;
        req_dev    = '0;
        poll_limit = 16'd1000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read(16'h1234, 5'h0a, 0, 2, 1000, "R4");
        t_write(16'hBEEF, 16'h7E57, 5'h1f, 3);
        t_read(16'h0001, 5'h13, 1, 0, 1000, "R3");
        t_read(16'hFE00, 5'h00, 2, 2, 3, "R7");
        t_timeout_pre(4, 4);
        t_timeout_pre(0, 1);
        t_timeout_post();
        t_write(16'h0200, 16'h0000, 5'h15, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule